// File: doc/BRIEF.md
# Bounded Start-Stop Scan Counter

This block is a synchronous up-counter with two programmable bounds. A load pulse copies a start value into the count and captures a stop value in the same cycle. While counting is enabled the count rises by one per clock. When it reaches the captured stop value it halts, raises a terminal flag and holds until the next load. A stop value below the start value makes the count wrap through the all-ones value and zero before it stops.

Two instances make a subwindow scanner. The column instance sweeps from the left edge of the window to the right edge. Its terminal flag advances the row instance and reloads the column instance. Both instances have the same interface.

Top module: `bounded_scan_counter`

## Requirements
- R1: A clock edge with `rst_n` low clears `count_q` to 0 and drives `running` and `at_stop` low. All outputs are valid from the next cycle.
- R2: A clock edge with `load` high sets `count_q` to `start_val`. Load takes priority over `count_en`, so the loaded value is not also incremented.
- R3: While `running` is high, each edge with `count_en` high and `load` low raises `count_q` by exactly one, modulo 2^CNT_W.
- R4: An edge with `count_en` low and `load` low leaves `count_q` unchanged.
- R5: On the edge where `count_q` becomes equal to the captured stop value, `at_stop` goes high and `running` goes low in that same cycle.
- R6: While `at_stop` is high, `count_q` and `at_stop` hold through any number of `count_en` edges until a load or reset.
- R7: When the stop value is less than the start value, the count wraps from 2^CNT_W-1 to 0 and halts at the stop value after (stop - start) mod 2^CNT_W steps.
- R8: A load whose `start_val` equals `stop_val` gives `at_stop` high and `running` low in the next cycle, with no counting.
- R9: `stop_val` is sampled only on a load edge. Changes to it at other times do not change where the count halts.
- R10: After reset and before the first load, `count_en` has no effect and `count_q` stays 0.
- R11: `running` and `at_stop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Load start value and capture stop value |
| count_en | input | 1 | Advance the count by one while running |
| start_val | input | CNT_W | First value of the sweep |
| stop_val | input | CNT_W | Value at which the sweep ends |
| count_q | output | CNT_W | Present count |
| at_stop | output | 1 | Count has reached the stop value |
| running | output | 1 | Sweep in progress |

## Verification
Every output comes from a register. A load, reset or enabled step therefore shows on `count_q`, `at_stop` and `running` one edge after the stimulus edge. The terminal flag changes on the same edge as the count that reaches the stop value, not one edge later. The bench drives inputs on the falling edge and samples on the next falling edge. After holding `count_en` for k edges, the expected count is start + min(k, distance) modulo 16, where distance is (stop - start) mod 16, and the expected flags come from comparing k with that distance.

// File: rtl/bsc_pkg.sv
// Package: shared types for the bounded scan counter.
// Assumes: one control state register per counter instance.
package bsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // reset, nothing loaded yet
        ST_RUN  = 2'd1,   // sweeping toward the stop bound
        ST_DONE = 2'd2    // bound reached, holding
    } bsc_state_e;
endpackage

// File: rtl/bsc_match.sv
// Module: bsc_match
// Purpose: equality comparator between two CNT_W-bit values.
// Assumes: purely combinational, no registers.
module bsc_match #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] a_val,
    input  logic [CNT_W-1:0] b_val,
    output logic             equal
);
    // compare the two operands bit for bit
    always_comb begin
        equal = (a_val == b_val);
    end
endmodule

// File: rtl/bsc_step.sv
// Module: bsc_step
// Purpose: forms the successor count (wrapping modulo 2^CNT_W) and flags
//          whether that successor lands on the captured bound.
// Assumes: the bound is held stable by the caller during a sweep.
module bsc_step #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cur_val,
    input  logic [CNT_W-1:0] bound_val,
    output logic [CNT_W-1:0] next_val,
    output logic             next_hits
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // increment with natural wrap
    always_comb begin
        next_val = cur_val + ONE;
    end

    bsc_match #(.CNT_W(CNT_W)) u_hit (
        .a_val (next_val),
        .b_val (bound_val),
        .equal (next_hits)
    );
endmodule

// File: rtl/bsc_ctrl.sv
// Module: bsc_ctrl
// Purpose: idle / run / done sequencing for one counter. Decides whether
//          the count advances this cycle and when the sweep ends.
// Assumes: load has priority over count_en; reset is synchronous, active low.
module bsc_ctrl
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       count_en,
    input  logic       load_is_stop,
    input  logic       step_hits,
    output bsc_state_e state_q,
    output logic       advance
);
    // state register: load restarts, reaching the bound finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (load) begin
            state_q <= load_is_stop ? ST_DONE : ST_RUN;
        end else if (state_q == ST_RUN && count_en && step_hits) begin
            state_q <= ST_DONE;
        end
    end

    // count advances only while running, enabled and not loading
    always_comb begin
        advance = (state_q == ST_RUN) && count_en && !load;
    end
endmodule

// File: rtl/bounded_scan_counter.sv
// Module: bounded_scan_counter (top)
// Purpose: loadable up-counter that halts at a stop value captured on load.
//          Used in pairs for row/column subwindow addressing.
// Assumes: synchronous active-low reset; all outputs registered.
module bounded_scan_counter
    import bsc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] stop_val,
    output logic [CNT_W-1:0] count_q,
    output logic             at_stop,
    output logic             running
);
    logic [CNT_W-1:0] stop_q;
    logic [CNT_W-1:0] next_val;
    logic             next_hits;
    logic             load_is_stop;
    logic             advance;
    bsc_state_e       state_q;

    bsc_match #(.CNT_W(CNT_W)) u_load_cmp (
        .a_val (start_val),
        .b_val (stop_val),
        .equal (load_is_stop)
    );

    bsc_step #(.CNT_W(CNT_W)) u_step (
        .cur_val   (count_q),
        .bound_val (stop_q),
        .next_val  (next_val),
        .next_hits (next_hits)
    );

    bsc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .count_en     (count_en),
        .load_is_stop (load_is_stop),
        .step_hits    (next_hits),
        .state_q      (state_q),
        .advance      (advance)
    );

    // count register: reset, load start, or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= start_val;
        end else if (advance) begin
            count_q <= next_val;
        end
    end

    // bound register: captured only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= '0;
        end else if (load) begin
            stop_q <= stop_val;
        end
    end

    // status outputs decoded from the state register
    always_comb begin
        running = (state_q == ST_RUN);
        at_stop = (state_q == ST_DONE);
    end
endmodule

// File: rtl/bounded_scan_counter_chk.sv
// Module: bounded_scan_counter_chk
// Purpose: temporal checks on the bounded scan counter, bound to the top.
// Assumes: observes ports plus the captured bound register.
module bounded_scan_counter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             count_en,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] stop_val,
    input logic [CNT_W-1:0] count_q,
    input logic             at_stop,
    input logic             running,
    input logic [CNT_W-1:0] stop_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count_q == '0) && !running && !at_stop);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(start_val));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && count_en && !load |=> count_q == $past(count_q) + ONE);

    // R4
    hold_idle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !count_en |=> $stable(count_q));

    // R5
    stop_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && count_en && !load && (count_q + ONE == stop_q) |=> at_stop && !running);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_stop && !load |=> at_stop && $stable(count_q));

    // R8
    equal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && (start_val == stop_val) |=> at_stop && !running);

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && at_stop));
endmodule

bind bounded_scan_counter bounded_scan_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .count_en  (count_en),
    .start_val (start_val),
    .stop_val  (stop_val),
    .count_q   (count_q),
    .at_stop   (at_stop),
    .running   (running),
    .stop_q    (stop_q)
);

// File: tb/bounded_scan_counter_test.sv
module bounded_scan_counter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         count_en = 1'b0;
    logic [W-1:0] start_val = '0;
    logic [W-1:0] stop_val = '0;
    logic [W-1:0] count_q;
    logic         at_stop;
    logic         running;

    int checks = 0;
    int failures = 0;

    // vector: start, stop, enabled edges, expected count, expected at_stop
    typedef struct packed {
        logic [3:0] s;
        logic [3:0] e;
        logic [7:0] k;
        logic [3:0] cnt;
        logic       done;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  4'd7, 8'd2,  4'd5,  1'b0},   // R3 mid sweep
        '{4'd3,  4'd7, 8'd4,  4'd7,  1'b1},   // R5 exact hit
        '{4'd3,  4'd7, 8'd9,  4'd7,  1'b1},   // R6 held after hit
        '{4'd12, 4'd2, 8'd3,  4'd15, 1'b0},   // R7 before wrap
        '{4'd12, 4'd2, 8'd6,  4'd2,  1'b1},   // R7 after wrap
        '{4'd0,  4'd15,8'd15, 4'd15, 1'b1},   // R5 full range
        '{4'd5,  4'd5, 8'd3,  4'd5,  1'b1},   // R8 equal bounds
        '{4'd15, 4'd0, 8'd1,  4'd0,  1'b1},   // R7 single wrap step
        '{4'd9,  4'd8, 8'd10, 4'd3,  1'b0},   // R7 long wrap
        '{4'd9,  4'd8, 8'd15, 4'd8,  1'b1}    // R5 longest sweep
    };

    bounded_scan_counter #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .count_en  (count_en),
        .start_val (start_val),
        .stop_val  (stop_val),
        .count_q   (count_q),
        .at_stop   (at_stop),
        .running   (running)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] s, input logic [W-1:0] e, input logic en);
        @(negedge clk);
        start_val = s; stop_val = e; load = 1'b1; count_en = en;
        @(negedge clk);
        load = 1'b0; count_en = 1'b0;
    endtask

    task automatic run(input int k);
        count_en = 1'b1;
        repeat (k) @(negedge clk);
        count_en = 1'b0;
    endtask

    initial begin
        #2000000;
        failures++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", int'(count_q), 0);
        check("R1 running", int'(running), 0);
        check("R1 at_stop", int'(at_stop), 0);

        // R10 enable before any load
        run(5);
        check("R10 idle count", int'(count_q), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].s, VECS[i].e, 1'b0);
            run(int'(VECS[i].k));
            check($sformatf("R5/R7 vec%0d count", i), int'(count_q), int'(VECS[i].cnt));
            check($sformatf("R5 vec%0d at_stop", i), int'(at_stop), int'(VECS[i].done));
            check($sformatf("R11 vec%0d running", i), int'(running), int'(!VECS[i].done));
        end

        // R2 load wins over count_en
        do_load(4'd6, 4'd10, 1'b1);
        check("R2 load priority", int'(count_q), 6);
        check("R2 running", int'(running), 1);

        // R4 hold without enable
        repeat (4) @(negedge clk);
        check("R4 hold", int'(count_q), 6);

        // R9 stop input change after load ignored
        stop_val = 4'd7;
        run(6);
        check("R9 count", int'(count_q), 10);
        check("R9 at_stop", int'(at_stop), 1);

        // R6 done holds with enable
        run(3);
        check("R6 count", int'(count_q), 10);

        // R1 reset in mid sweep
        do_load(4'd1, 4'd14, 1'b0);
        run(3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid count", int'(count_q), 0);
        check("R1 mid running", int'(running), 0);
        check("R1 mid at_stop", int'(at_stop), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule